// File: doc/BRIEF.md
# SAV-Aligned Line FIFO Load Strobe

This block sits on a 10-bit parallel video word stream clocked by the pixel clock. It watches for timing reference sequences: a 3FF word followed by two 000 words and then an XYZ word. It reads the XYZ word to tell a start-of-active-video reference from an end-of-active-video reference. For each start-of-active-video reference it drives an active-low strobe for one clock. That strobe write-resets an external line FIFO.

The video words pass through a register pipeline of fixed length. The strobe travels through a pipeline of the same length, so it is low in exactly the cycle in which the start-of-active-video XYZ word is on the output bus. The word on the next clock is then the first active sample of the line, and the FIFO starts that line at address zero. The strobe is generated only while the standard video processing mode input is high.

Top module: `sav_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `load_n` is 1 and `dout` is 0.
- R2: `load_n` rests at 1 and is never low for two clocks in a row.
- R3: `dout` equals the `din` word sampled LAT clocks earlier (LAT parameter, default 3).
- R4: `load_n` is 0 in exactly the cycle in which `dout` carries an XYZ word that follows the preamble 3FF, 000, 000 and whose bit 6 is 0 (start of active video). The word on `dout` in the next cycle is the first active sample.
- R5: An XYZ word whose bit 6 is 1 (end of active video) never causes `load_n` to go low.
- R6: A preamble broken by a wrong word produces no strobe. If the wrong word is 3FF, it is taken as the start of a new preamble. For example, 3FF, 000, 3FF, 000, 000, then an XYZ word with bit 6 at 0, gives one strobe.
- R7: An XYZ word sampled while `vid_en` is 0 produces no strobe, so `load_n` stays 1.
- R8: A word after a complete preamble is always taken as the XYZ word. Detection then starts again from the following word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| vid_en | input | 1 | High selects standard video processing mode |
| din | input | 10 | Parallel video word in |
| dout | output | 10 | Video word delayed by LAT clocks |
| load_n | output | 1 | Active-low FIFO write-reset strobe, co-timed with the start-of-active-video XYZ word on dout |

## Verification
The assertions assume a legal video stream: an XYZ word is never 3FF, and references are at least four words apart, so two strobes can never sit side by side. The stimulus builds lines from a fixed set of words: blanking values, reference sequences with chosen XYZ words, and ramps of active samples. None of these words is a preamble pattern by accident. Broken preambles are injected on purpose, and `vid_en` changes only between lines.

// File: rtl/sav_strobe_pkg.sv
package sav_strobe_pkg;
  localparam int unsigned WORD_W = 10;
  localparam int unsigned H_BIT  = 6;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ONES = 2'd1,
    S_Z1   = 2'd2,
    S_Z2   = 2'd3
  } trs_st_e;
endpackage

// File: rtl/trs_detect.sv
module trs_detect
  import sav_strobe_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic         xyz_now
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};

  trs_st_e st_q, st_d;

  always_comb begin
    st_d = S_IDLE;
    unique case (st_q)
      S_Z2:    st_d = S_IDLE;
      S_ONES:  st_d = (din == ALL_ZERO) ? S_Z1 : ((din == ALL_ONES) ? S_ONES : S_IDLE);
      S_Z1:    st_d = (din == ALL_ZERO) ? S_Z2 : ((din == ALL_ONES) ? S_ONES : S_IDLE);
      default: st_d = (din == ALL_ONES) ? S_ONES : S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign xyz_now = (st_q == S_Z2);

  a_r6_ones_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ONES) |-> ($past(din) == ALL_ONES));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_Z2 && din == ALL_ONES) |=> (st_q == S_ONES));

  a_r8_xyz_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_Z2) |=> (st_q != S_Z2));
endmodule

// File: rtl/sav_classify.sv
module sav_classify (
  input  logic xyz_now,
  input  logic h_bit,
  input  logic mode_en,
  output logic sav_hit
);
  assign sav_hit = xyz_now & ~h_bit & mode_en;
endmodule

// File: rtl/lat_pipe.sv
module lat_pipe #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q = stg_q[DEPTH-1];
endmodule

// File: rtl/sav_strobe_gen.sv
module sav_strobe_gen
  import sav_strobe_pkg::*;
#(
  parameter int unsigned LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vid_en,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              load_n
);
  localparam int unsigned DEPTH = (LAT < 1) ? 1 : LAT;

  logic xyz_now;
  logic sav_hit;
  logic [0:0] hit_del;

  trs_detect #(.W(WORD_W)) u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .xyz_now (xyz_now)
  );

  sav_classify u_classify (
    .xyz_now (xyz_now),
    .h_bit   (din[H_BIT]),
    .mode_en (vid_en),
    .sav_hit (sav_hit)
  );

  lat_pipe #(.W(WORD_W), .DEPTH(DEPTH), .RST_VAL('0)) u_data_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (din),
    .q     (dout)
  );

  lat_pipe #(.W(1), .DEPTH(DEPTH), .RST_VAL(1'b0)) u_hit_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sav_hit),
    .q     (hit_del)
  );

  assign load_n = ~hit_del[0];

  a_r2_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> load_n);

  a_r4_after_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> ($past(dout, 3) == {WORD_W{1'b1}} && $past(dout, 2) == '0
                 && $past(dout, 1) == '0));

  a_r5_not_eav: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> !dout[H_BIT]);

  always_comb begin
    if (!rst_n) a_r1_reset_idle: assert (load_n && dout == '0);
  end
endmodule

// File: tb/sav_strobe_gen_bench.sv
module sav_strobe_gen_bench;
  localparam int LAT = 3;

  typedef struct {
    logic [9:0] data;
    logic       load_n;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vid_en = 1'b0;
  logic [9:0] din = '0;
  logic [9:0] dout;
  logic       load_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [9:0] h1 = '0, h2 = '0, h3 = '0;
  string cur_tag = "R3";
  int pulses = 0;

  always #10 clk = ~clk;

  sav_strobe_gen #(.LAT(LAT)) u_sav_strobe_gen (
    .clk(clk), .rst_n(rst_n), .vid_en(vid_en),
    .din(din), .dout(dout), .load_n(load_n)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor half: compare the oldest expected item with the outputs.
  task automatic monitor_pop();
    exp_t e;
    if (sb.size() >= LAT) begin
      e = sb.pop_front();
      check(dout == e.data, e.tag, "dout", dout, e.data);
      check(load_n == e.load_n, (e.load_n ? e.tag : "R4"), "load_n", load_n, e.load_n);
      if (!load_n) pulses++;
    end
  endtask

  // Driver: one word per clock, expected result pushed to the scoreboard.
  task automatic drive(input logic [9:0] w);
    exp_t e;
    bit sav;
    @(negedge clk);
    monitor_pop();
    din = w;
    sav = (h3 == 10'h3FF) && (h2 == 10'h000) && (h1 == 10'h000) && !w[6] && vid_en;
    e.data = w;
    e.load_n = ~sav;
    e.tag = cur_tag;
    sb.push_back(e);
    h3 = h2; h2 = h1; h1 = w;
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) drive((i % 2) ? 10'h040 : 10'h200);
  endtask

  task automatic trs(input logic [9:0] xyz);
    drive(10'h3FF); drive(10'h000); drive(10'h000); drive(xyz);
  endtask

  task automatic active(input int n);
    for (int i = 0; i < n; i++) drive(10'h100 + 10'(i * 7));
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 1; i++) drive(10'h200);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p0;
    // R1: outputs idle while reset is held, even with a preamble applied
    vid_en = 1'b1;
    repeat (2) @(negedge clk);
    din = 10'h3FF;
    @(negedge clk);
    check(load_n == 1'b1, "R1", "load_n in reset", load_n, 1);
    check(dout == 10'h000, "R1", "dout in reset", dout, 0);
    din = 10'h000;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: normal lines, EAV then SAV then active samples
    cur_tag = "R3";
    blank(6);
    cur_tag = "R5"; trs(10'h274);
    cur_tag = "R3"; blank(8);
    p0 = pulses;
    trs(10'h200); active(12);
    cur_tag = "R5"; trs(10'h2D8);
    cur_tag = "R3"; blank(5);
    trs(10'h2AC); active(6);
    flush();
    check(pulses - p0 == 2, "R4", "pulse count two lines", pulses - p0, 2);

    // R5: EAV codes only
    p0 = pulses;
    cur_tag = "R5";
    trs(10'h274); blank(3); trs(10'h3C4); blank(3);
    flush();
    check(pulses == p0, "R5", "no pulse on EAV", pulses - p0, 0);

    // R6: broken preambles
    cur_tag = "R6";
    p0 = pulses;
    drive(10'h3FF); drive(10'h000); drive(10'h123); drive(10'h000); drive(10'h000);
    drive(10'h200); blank(4);
    flush();
    check(pulses == p0, "R6", "no pulse after wrong word", pulses - p0, 0);
    p0 = pulses;
    drive(10'h3FF); drive(10'h000); drive(10'h3FF); drive(10'h000); drive(10'h000);
    drive(10'h200); active(4);
    drive(10'h3FF); drive(10'h3FF); drive(10'h000); drive(10'h000);
    drive(10'h2AC); active(3);
    flush();
    check(pulses - p0 == 2, "R6", "pulse after restarted preamble", pulses - p0, 2);

    // R8: a 000 XYZ word is still classified and consumed
    cur_tag = "R8";
    p0 = pulses;
    trs(10'h000); drive(10'h000); drive(10'h000); active(3);
    flush();
    check(pulses - p0 == 1, "R8", "xyz consumed once", pulses - p0, 1);

    // R7: mode disabled
    cur_tag = "R7";
    blank(2);
    vid_en = 1'b0;
    p0 = pulses;
    trs(10'h200); active(4); trs(10'h2AC); active(4);
    flush();
    check(pulses == p0, "R7", "no pulse with mode off", pulses - p0, 0);
    vid_en = 1'b1;
    cur_tag = "R3";
    p0 = pulses;
    blank(2); trs(10'h200); active(4);
    flush();
    check(pulses - p0 == 1, "R7", "pulse again with mode on", pulses - p0, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule